// File: doc/BRIEF.md
# Compressed Program-Counter Trace Encoder

The block watches a stream of 18-bit program-counter values, one for each instruction strobe, and packs them into 20-bit trace lines for a circular trace memory. Each line has a 2-bit info code and an 18-bit payload. A line holds either a complete PC, which becomes the base, or up to three 6-bit offsets. Each offset is measured from the bottom of the 64-address window that contains the current base. A PC that leaves that window starts a new base line. This way, straight-line code costs about one third of a line for each instruction.

A level input marks the trace session. The cycle in which it rises starts a fresh session: the write pointer, the line count and the rollover flag clear, and the first line written is forced to be a base line. The cycle in which it falls commits any line that is still partly filled. The block drives a single write port to the trace memory. It also reports how many lines are valid, whether the pointer has wrapped, and where the oldest entry is, so that a reader can rebuild the program flow.

Lines are built one step behind the PCs, in an open-line register. Because of this, each PC strobe commits at most one line. After the pointer wraps, the next line written is always a base line.

Top module: `pcz_trace_enc`

## Requirements
- R1: A base line has info code 00, and its payload is the complete 18-bit PC.
- R2: A PC that arrives while no base has yet been opened in the session, or whose bits [17:6] differ from the current base, opens a new base line. Any line that was open is written first.
- R3: An offset line carries PC[5:0] of each PC. The first offset goes in payload[5:0], the second in [11:6] and the third in [17:12], and unused upper fields are zero. The info code gives the number of offsets: 01 means one, 10 means two, 11 means three.
- R4: The first line written in a session, which goes to address 0, is a base line.
- R5: After the write pointer wraps from 63 to 0, the next line written is a base line. A base line written to address 63 and followed by a PC in the same window is replaced by a new base line for that PC.
- R6: An open line is committed when its third offset arrives, when a window change forces a new base, or in the cycle in which the trace enable falls. The write port shows the line one cycle after the strobe or enable edge that completed it.
- R7: Within a session, lines go to consecutive addresses starting at 0 and wrapping modulo 64. A sticky rollover flag is set by the write to address 63 and cleared only when a new session starts.
- R8: The valid-line count equals the number of lines written in the session and saturates at 64.
- R9: The oldest-entry pointer is 0 while no rollover has occurred, and equals the next write address once rollover has occurred.
- R10: A PC strobe that arrives while the trace enable is low, and any cycle with the PC strobe low, writes nothing and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en_i | input | 1 | Session level: rising starts a session, falling ends it and flushes |
| pc_valid_i | input | 1 | Instruction strobe, qualifies pc_i |
| pc_i | input | 18 | Program counter of the executed instruction |
| wr_en_o | output | 1 | Trace memory write enable |
| wr_addr_o | output | 6 | Trace memory write address |
| wr_data_o | output | 20 | Trace line: info code in [19:18], payload in [17:0] |
| line_count_o | output | 7 | Valid lines in the trace memory, saturating at 64 |
| rollover_o | output | 1 | Sticky: the write pointer has wrapped in this session |
| oldest_ptr_o | output | 6 | Address of the oldest valid line |

## Verification
The bench sweeps window run lengths from one to five PCs, two offset starting points, optional strobe gaps and session lengths on both sides of the 64-line wrap. This makes every open-line state meet every pointer position, including a base line landing on address 63. A design that keeps the open offset line across the wrap would write an offset line at address 0 that has no base, and the address-0 check would catch it. Short sessions that stop with one or two offsets pending catch a design that loses its last line on a flush or leaves stale upper fields. A design that counts or writes while the enable is low shows a changed count or an unexpected write, and one that never saturates its count or points the oldest pointer at 0 after a wrap fails the end-of-session checks.

// File: rtl/pcz_pkg.sv
package pcz_pkg;

    typedef enum logic [1:0] {
        LINE_NONE = 2'd0,
        LINE_BASE = 2'd1,
        LINE_OFS  = 2'd2
    } open_e;

    localparam logic [1:0] INFO_BASE = 2'b00;

endpackage

// File: rtl/pcz_win_cmp.sv
module pcz_win_cmp #(
    parameter int PC_W  = 18,
    parameter int OFS_W = 6,
    localparam int WIN_W = PC_W - OFS_W
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [WIN_W-1:0] base_win_i,
    input  logic             force_i,
    output logic             need_base_o,
    output logic [OFS_W-1:0] ofs_o,
    output logic [WIN_W-1:0] win_o
);

    always_comb begin
        win_o       = pc_i[PC_W-1:OFS_W];
        ofs_o       = pc_i[OFS_W-1:0];
        need_base_o = force_i || (pc_i[PC_W-1:OFS_W] != base_win_i);
    end

endmodule

// File: rtl/pcz_line_fmt.sv
module pcz_line_fmt #(
    parameter int PC_W  = 18,
    parameter int OFS_W = 6,
    parameter int SLOTS = 3,
    localparam int LINE_W = PC_W + 2
) (
    input  logic              is_base_i,
    input  logic [1:0]        n_ofs_i,
    input  logic [PC_W-1:0]   pay_i,
    output logic [LINE_W-1:0] line_o
);

    logic [PC_W-1:0] kept;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign kept[s*OFS_W +: OFS_W] =
            (is_base_i || ({30'd0, n_ofs_i} > s)) ? pay_i[s*OFS_W +: OFS_W] : '0;
    end

    assign line_o = {(is_base_i ? pcz_pkg::INFO_BASE : n_ofs_i), kept};

endmodule

// File: rtl/pcz_wptr.sv
module pcz_wptr #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          wr_i,
    output logic [AW-1:0] ptr_o,
    output logic          last_o,
    output logic          rollover_o,
    output logic [CW-1:0] count_o,
    output logic [AW-1:0] oldest_o
);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          roll;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic at_last;

    always_comb begin
        at_last = (ptr_q.ptr == AW'(DEPTH - 1));
        ptr_d   = ptr_q;
        if (clear_i) begin
            ptr_d = '0;
        end else if (wr_i) begin
            ptr_d.ptr = at_last ? '0 : ptr_q.ptr + 1'b1;
            if (at_last) begin
                ptr_d.roll = 1'b1;
            end
            if (ptr_q.cnt != CW'(DEPTH)) begin
                ptr_d.cnt = ptr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o      = ptr_q.ptr;
    assign last_o     = at_last;
    assign rollover_o = ptr_q.roll;
    assign count_o    = ptr_q.cnt;
    assign oldest_o   = ptr_q.roll ? ptr_q.ptr : '0;

endmodule

// File: rtl/pcz_trace_enc.sv
module pcz_trace_enc #(
    parameter int PC_W  = 18,
    parameter int OFS_W = 6,
    parameter int SLOTS = 3,
    parameter int DEPTH = 64,
    localparam int WIN_W  = PC_W - OFS_W,
    localparam int LINE_W = PC_W + 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en_i,
    input  logic              pc_valid_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [LINE_W-1:0] wr_data_o,
    output logic [CW-1:0]     line_count_o,
    output logic              rollover_o,
    output logic [AW-1:0]     oldest_ptr_o
);

    import pcz_pkg::*;

    typedef struct packed {
        logic            active;
        open_e           open_k;
        logic [1:0]      n;
        logic [PC_W-1:0] pay;
        logic [WIN_W-1:0] win;
        logic            force_base;
        logic            em_v;
        logic            em_base;
        logic [1:0]      em_n;
        logic [PC_W-1:0] em_pay;
        logic [AW-1:0]   em_addr;
    } enc_t;

    localparam enc_t ENC_RST = '{
        active: 1'b0, open_k: LINE_NONE, n: '0, pay: '0, win: '0,
        force_base: 1'b1, em_v: 1'b0, em_base: 1'b0, em_n: '0,
        em_pay: '0, em_addr: '0
    };

    enc_t enc_d, enc_q, cur;

    logic             start;
    logic             need_base;
    logic [OFS_W-1:0] pc_ofs;
    logic [WIN_W-1:0] pc_win;
    logic [PC_W-1:0]  ofs_ext;
    logic [AW-1:0]    wptr;
    logic             wptr_last;

    assign start = trace_en_i && !enc_q.active;

    pcz_win_cmp #(.PC_W(PC_W), .OFS_W(OFS_W)) win_cmp_i (
        .pc_i        (pc_i),
        .base_win_i  (enc_q.win),
        .force_i     (enc_q.force_base || start),
        .need_base_o (need_base),
        .ofs_o       (pc_ofs),
        .win_o       (pc_win)
    );

    assign ofs_ext = {{(PC_W-OFS_W){1'b0}}, pc_ofs};

    always_comb begin
        cur = enc_q;
        if (start) begin
            cur.open_k     = LINE_NONE;
            cur.n          = '0;
            cur.pay        = '0;
            cur.force_base = 1'b1;
        end
        enc_d         = cur;
        enc_d.active  = trace_en_i;
        enc_d.em_v    = 1'b0;
        enc_d.em_base = 1'b0;
        enc_d.em_n    = '0;
        enc_d.em_pay  = '0;
        enc_d.em_addr = wptr;

        if (trace_en_i && pc_valid_i) begin
            if (need_base) begin
                if (cur.open_k != LINE_NONE) begin
                    enc_d.em_v    = 1'b1;
                    enc_d.em_base = (cur.open_k == LINE_BASE);
                    enc_d.em_n    = cur.n;
                    enc_d.em_pay  = cur.pay;
                end
                enc_d.open_k     = LINE_BASE;
                enc_d.n          = '0;
                enc_d.pay        = pc_i;
                enc_d.win        = pc_win;
                enc_d.force_base = 1'b0;
            end else if (cur.open_k == LINE_BASE) begin
                enc_d.em_v    = 1'b1;
                enc_d.em_base = 1'b1;
                enc_d.em_pay  = cur.pay;
                if (wptr_last) begin
                    enc_d.pay = pc_i;
                end else begin
                    enc_d.open_k = LINE_OFS;
                    enc_d.n      = 2'd1;
                    enc_d.pay    = ofs_ext;
                end
            end else if (cur.open_k == LINE_NONE) begin
                enc_d.open_k = LINE_OFS;
                enc_d.n      = 2'd1;
                enc_d.pay    = ofs_ext;
            end else if (cur.n == 2'(SLOTS - 1)) begin
                enc_d.em_v   = 1'b1;
                enc_d.em_n   = 2'(SLOTS);
                enc_d.em_pay = cur.pay | (ofs_ext << (OFS_W * (SLOTS - 1)));
                enc_d.open_k = LINE_NONE;
                enc_d.n      = '0;
                enc_d.pay    = '0;
                if (wptr_last) begin
                    enc_d.force_base = 1'b1;
                end
            end else begin
                enc_d.pay = cur.pay | (ofs_ext << (OFS_W * int'(cur.n)));
                enc_d.n   = cur.n + 2'd1;
            end
        end else if (!trace_en_i && enc_q.active && enc_q.open_k != LINE_NONE) begin
            enc_d.em_v    = 1'b1;
            enc_d.em_base = (enc_q.open_k == LINE_BASE);
            enc_d.em_n    = enc_q.n;
            enc_d.em_pay  = enc_q.pay;
            enc_d.open_k  = LINE_NONE;
            enc_d.n       = '0;
            enc_d.pay     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q <= ENC_RST;
        end else begin
            enc_q <= enc_d;
        end
    end

    pcz_wptr #(.DEPTH(DEPTH)) wptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start),
        .wr_i       (enc_d.em_v),
        .ptr_o      (wptr),
        .last_o     (wptr_last),
        .rollover_o (rollover_o),
        .count_o    (line_count_o),
        .oldest_o   (oldest_ptr_o)
    );

    pcz_line_fmt #(.PC_W(PC_W), .OFS_W(OFS_W), .SLOTS(SLOTS)) line_fmt_i (
        .is_base_i (enc_q.em_base),
        .n_ofs_i   (enc_q.em_n),
        .pay_i     (enc_q.em_pay),
        .line_o    (wr_data_o)
    );

    assign wr_en_o   = enc_q.em_v;
    assign wr_addr_o = enc_q.em_addr;

endmodule

// File: rtl/pcz_trace_enc_chk.sv
module pcz_trace_enc_chk #(
    parameter int PC_W  = 18,
    parameter int OFS_W = 6,
    parameter int SLOTS = 3,
    parameter int DEPTH = 64,
    localparam int LINE_W = PC_W + 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trace_en_i,
    input logic              wr_en_o,
    input logic [AW-1:0]     wr_addr_o,
    input logic [LINE_W-1:0] wr_data_o,
    input logic [CW-1:0]     line_count_o,
    input logic              rollover_o,
    input logic [AW-1:0]     oldest_ptr_o
);

    logic [1:0]      info;
    logic [PC_W-1:0] pay;
    logic [PC_W-1:0] upper;

    assign info  = wr_data_o[LINE_W-1:PC_W];
    assign pay   = wr_data_o[PC_W-1:0];
    assign upper = pay >> (OFS_W * int'(info));

    // R4 and R5: address 0 only ever receives a base line
    assert_addr0_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && wr_addr_o == '0 |-> info == 2'b00);

    // R3: fields above the used offsets are zero
    assert_ofs_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && info != 2'b00 && int'(info) < SLOTS |-> upper == '0);

    // R8: count saturated once wrapped
    assert_count_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rollover_o |-> line_count_o == CW'(DEPTH));

    // R9: oldest entry is line 0 before any wrap
    assert_oldest_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rollover_o |-> oldest_ptr_o == '0);

    // R7: before a wrap, count follows the write address
    assert_count_follows_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && !rollover_o |-> line_count_o == CW'(wr_addr_o) + 1'b1);

    // R7: rollover stays set inside a session
    assert_rollover_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rollover_o && trace_en_i && $past(trace_en_i) |=> rollover_o);

endmodule

bind pcz_trace_enc pcz_trace_enc_chk #(
    .PC_W(PC_W), .OFS_W(OFS_W), .SLOTS(SLOTS), .DEPTH(DEPTH)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trace_en_i   (trace_en_i),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .line_count_o (line_count_o),
    .rollover_o   (rollover_o),
    .oldest_ptr_o (oldest_ptr_o)
);

// File: tb/pcz_trace_enc_tb_top.sv
module pcz_trace_enc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en_i = 1'b0;
    logic        pc_valid_i = 1'b0;
    logic [17:0] pc_i = '0;
    logic        wr_en_o;
    logic [5:0]  wr_addr_o;
    logic [19:0] wr_data_o;
    logic [6:0]  line_count_o;
    logic        rollover_o;
    logic [5:0]  oldest_ptr_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pcz_trace_enc dut_i (
        .clk(clk), .rst_n(rst_n), .trace_en_i(trace_en_i),
        .pc_valid_i(pc_valid_i), .pc_i(pc_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .line_count_o(line_count_o), .rollover_o(rollover_o),
        .oldest_ptr_o(oldest_ptr_o)
    );

    // expected write stream: {addr, info, payload}
    logic [25:0] exp_q[$];
    int          m_lines;
    int          m_open;
    int          m_n;
    logic [17:0] m_pay;
    logic [11:0] m_win;
    logic        m_force;
    bit          done = 0;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic m_emit(input logic [1:0] info, input logic [17:0] pay);
        exp_q.push_back({6'(m_lines % 64), info, pay});
        m_lines++;
    endtask

    // R1 R2 R3 R5 R6: expected lines for one accepted PC
    task automatic model_pc(input logic [17:0] pc);
        logic [17:0] ofs;
        bit last;
        ofs  = {12'd0, pc[5:0]};
        last = (m_lines % 64) == 63;
        if (m_force || pc[17:6] != m_win) begin
            if (m_open != 0) m_emit(m_open == 1 ? 2'b00 : 2'(m_n), m_pay);
            m_open = 1; m_pay = pc; m_win = pc[17:6]; m_force = 0;
        end else if (m_open == 1) begin
            m_emit(2'b00, m_pay);
            if (last) m_pay = pc;
            else begin m_open = 2; m_n = 1; m_pay = ofs; end
        end else if (m_open == 0) begin
            m_open = 2; m_n = 1; m_pay = ofs;
        end else if (m_n == 2) begin
            m_emit(2'b11, m_pay | (ofs << 12));
            m_open = 0; m_n = 0;
            if (last) m_force = 1;
        end else begin
            m_pay = m_pay | (ofs << 6); m_n = 2;
        end
    endtask

    task automatic model_stop();
        if (m_open != 0) m_emit(m_open == 1 ? 2'b00 : 2'(m_n), m_pay);
        m_open = 0;
    endtask

    // write monitor
    always @(negedge clk) begin
        if (rst_n && !done && wr_en_o) begin
            if (exp_q.size() == 0) begin
                check(0, "R6 R10 unexpected write", {wr_addr_o, wr_data_o}, 0);
            end else begin
                logic [25:0] e;
                e = exp_q.pop_front();
                check(wr_addr_o == e[25:20], "R7 write address", wr_addr_o, e[25:20]);
                check(wr_data_o == e[19:0],
                      (e[19:18] == 2'b00) ? "R1 R2 base line" : "R3 offset line",
                      wr_data_o, e[19:0]);
                if (wr_addr_o == 6'd0)
                    check(wr_data_o[19:18] == 2'b00, "R4 R5 line at address 0 is base",
                          wr_data_o[19:18], 0);
            end
        end
    end

    task automatic run_session(input int n_pc, input int run_len, input int ofs0, input int gap_mod);
        @(posedge clk); #1;
        trace_en_i = 1'b1;
        m_lines = 0; m_open = 0; m_n = 0; m_pay = '0; m_win = '0; m_force = 1;
        for (int i = 0; i < n_pc; i++) begin
            logic [17:0] pc;
            pc = 18'((i / run_len) * 64 * 7 + ((ofs0 + 5 * (i % run_len)) % 64));
            if (gap_mod > 0 && (i % gap_mod) == gap_mod - 1) begin
                pc_valid_i = 1'b0;       // R10: strobe low, nothing accepted
                pc_i = 18'h3ffff;
                @(posedge clk); #1;
            end
            pc_valid_i = 1'b1;
            pc_i = pc;
            model_pc(pc);
            @(posedge clk); #1;
        end
        pc_valid_i = 1'b0;
        trace_en_i = 1'b0;
        model_stop();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R6 all lines committed after stop", exp_q.size(), 0);
        check(line_count_o == 7'((m_lines >= 64) ? 64 : m_lines), "R8 line count",
              line_count_o, (m_lines >= 64) ? 64 : m_lines);
        check(rollover_o == (m_lines >= 64), "R7 rollover flag", rollover_o, m_lines >= 64);
        check(oldest_ptr_o == 6'((m_lines >= 64) ? m_lines % 64 : 0), "R9 oldest pointer",
              oldest_ptr_o, (m_lines >= 64) ? m_lines % 64 : 0);
        exp_q.delete();
    endtask

    // R10: strobes with tracing off change nothing
    task automatic idle_strobes();
        logic [6:0] cnt0;
        cnt0 = line_count_o;
        @(posedge clk); #1;
        for (int i = 0; i < 5; i++) begin
            pc_valid_i = 1'b1;
            pc_i = 18'(i * 4099);
            @(posedge clk); #1;
        end
        pc_valid_i = 1'b0;
        @(negedge clk);
        check(line_count_o == cnt0, "R10 count unchanged while disabled", line_count_o, cnt0);
    endtask

    initial begin
        int n_list[10] = '{1, 2, 3, 4, 7, 40, 63, 150, 190, 200};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(wr_en_o == 1'b0, "R6 reset write enable", wr_en_o, 0);
        check(line_count_o == '0, "R8 reset count", line_count_o, 0);
        check(rollover_o == 1'b0, "R7 reset rollover", rollover_o, 0);
        check(oldest_ptr_o == '0, "R9 reset oldest pointer", oldest_ptr_o, 0);
        rst_n = 1'b1;
        for (int rl = 1; rl <= 5; rl++)
            for (int oi = 0; oi < 2; oi++)
                for (int g = 0; g < 2; g++)
                    for (int k = 0; k < 10; k++) begin
                        run_session(n_list[k], rl, oi * 60, g * 4);
                        idle_strobes();
                    end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule